// File: doc/BRIEF.md
# Key-Unlocked Board Control Register

This block is a 16-bit control register for a board management device. Its low byte is an ordinary read/write field. Each of its eight bits drives one board-level line:

- bits 0 and 1: the two motion-sensor interrupt lines;
- bit 2: the real-time-clock interrupt/reset line;
- bit 3: the Ethernet transceiver interrupt line;
- bit 4: the high-speed USB transceiver reset;
- bit 5: the Ethernet transceiver reset;
- bit 6: the memory card controller reset;
- bit 7: the Ethernet reference clock enable.

The upper byte is never stored. Each written upper byte goes to a small key detector instead. That detector turns on one of two one-way enables only after it sees an ordered pair of key bytes on successive writes:

- a watchdog enable;
- an auxiliary ("extra") enable.

A single stray write therefore cannot start the watchdog. Once an enable is on, software cannot turn it off. Only reset clears it. Writes are single-cycle strobes carrying 16 bits of data. The read value is combinational from the stored state.

Top module: `keyed_ctrl_reg`

## Requirements
- R1: After reset, ctrlOut is 0x70: bits 4, 5 and 6 are 1, holding the USB, Ethernet and card devices in reset, and all other bits are 0. wdogEn and extraEn are 0 and rdData is 0x0070.
- R2: A cycle with wrEn high loads wrData[7:0] into ctrlOut at that clock edge. Every bit takes its own written value regardless of the others.
- R3: In a cycle with wrEn low, ctrlOut, wdogEn, extraEn and the key detector keep their values.
- R4: A write whose upper byte is 0xE5, followed by the next write whose upper byte is 0xA5, sets wdogEn at the edge of the second write. Idle cycles between the two writes are allowed.
- R5: A write whose upper byte is 0xA5, followed by the next write whose upper byte is 0xE5, sets extraEn at the edge of the second write.
- R6: A write whose upper byte is neither key byte aborts a half-entered sequence. The detector returns to idle, and the later completing byte has no effect.
- R7: Repeating the first key byte keeps the sequence armed. For example, 0xE5, 0xE5, 0xA5 sets wdogEn.
- R8: Once set, wdogEn and extraEn stay 1 until reset, whatever is written.
- R9: rdData[7:0] is ctrlOut, rdData[8] is wdogEn, rdData[9] is extraEn, and rdData[15:10] is 0.
- R10: The byte that completes a sequence does not also count as the first byte of the other sequence. For example, 0xE5, 0xA5, 0xE5 leaves extraEn clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe, already address-decoded |
| wrData | input | 16 | Write data; [7:0] is the control byte, [15:8] is the key byte |
| ctrlOut | output | 8 | Control and reset lines |
| wdogEn | output | 1 | Watchdog enable, one-way |
| extraEn | output | 1 | Auxiliary enable, one-way |
| rdData | output | 16 | Read-back of the control byte and both enables |

## Verification
The detector state cannot be seen directly. A wrong state shows up at the ports only on the next write that carries a key byte: an enable rises one write too early, or fails to rise on the completing write. The bench therefore places completing bytes right after aborts, repeats and completed sequences, so that any hidden state error shows within one clock.

Errors in the low byte or in the one-way enables show on the very next edge. The bench compares every output against a behavioural model on every cycle.

// File: rtl/keyed_ctrl_pkg.sv
package keyed_ctrl_pkg;

  typedef enum logic [1:0] {
    KEY_IDLE  = 2'd0,
    KEY_GOT_W = 2'd1,
    KEY_GOT_X = 2'd2
  } keyState_t;

  typedef struct packed {
    logic loadLow;
    logic setWdog;
    logic setExtra;
  } ctrlStrobes_t;

endpackage

// File: rtl/keyed_ctrl_fsm.sv
module keyed_ctrl_fsm
  import keyed_ctrl_pkg::*;
#(
  parameter int KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY_A = 8'hE5,
  parameter logic [KEY_W-1:0] KEY_B = 8'hA5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [KEY_W-1:0] keyByte,
  output ctrlStrobes_t     strobes
);

  keyState_t curState, nextState;

  always_comb begin
    nextState        = curState;
    strobes.loadLow  = wrEn;
    strobes.setWdog  = 1'b0;
    strobes.setExtra = 1'b0;
    if (wrEn) begin
      unique case (curState)
        KEY_IDLE: begin
          if (keyByte == KEY_A)      nextState = KEY_GOT_W;
          else if (keyByte == KEY_B) nextState = KEY_GOT_X;
        end
        KEY_GOT_W: begin
          if (keyByte == KEY_B) begin
            strobes.setWdog = 1'b1;
            nextState       = KEY_IDLE;
          end else if (keyByte != KEY_A) begin
            nextState = KEY_IDLE;
          end
        end
        KEY_GOT_X: begin
          if (keyByte == KEY_A) begin
            strobes.setExtra = 1'b1;
            nextState        = KEY_IDLE;
          end else if (keyByte != KEY_B) begin
            nextState = KEY_IDLE;
          end
        end
        default: nextState = KEY_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= KEY_IDLE;
    else       curState <= nextState;
  end

  // R6: a byte other than a key byte always drops an armed detector
  a_r6_abort_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && curState != KEY_IDLE && keyByte != KEY_A && keyByte != KEY_B)
      |=> curState == KEY_IDLE);

  // R3: no write, no state change
  a_r3_state_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(curState));

  // R10: a completed sequence leaves the detector idle
  a_r10_complete_idle: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.setWdog || strobes.setExtra) |=> curState == KEY_IDLE);

endmodule

// File: rtl/keyed_ctrl_dp.sv
module keyed_ctrl_dp
  import keyed_ctrl_pkg::*;
#(
  parameter int CTRL_W = 8,
  parameter logic [CTRL_W-1:0] LOW_RST = 8'h70
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [CTRL_W-1:0] lowByte,
  output logic [CTRL_W-1:0] ctrlOut,
  output logic              wdogEn,
  output logic              extraEn
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlOut <= LOW_RST;
      wdogEn  <= 1'b0;
      extraEn <= 1'b0;
    end else begin
      if (strobes.loadLow)  ctrlOut <= lowByte;
      if (strobes.setWdog)  wdogEn  <= 1'b1;
      if (strobes.setExtra) extraEn <= 1'b1;
    end
  end

  a_r2_low_load: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadLow |=> ctrlOut == $past(lowByte));

  a_r3_low_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadLow |=> $stable(ctrlOut));

  a_r8_wdog_sticky: assert property (@(posedge clk) disable iff (!rstN)
    wdogEn |=> wdogEn);

  a_r8_extra_sticky: assert property (@(posedge clk) disable iff (!rstN)
    extraEn |=> extraEn);

endmodule

// File: rtl/keyed_ctrl_reg.sv
module keyed_ctrl_reg
  import keyed_ctrl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CTRL_W = 8,
  parameter logic [CTRL_W-1:0] LOW_RST = 8'h70,
  parameter logic [DATA_W-CTRL_W-1:0] KEY_A = 8'hE5,
  parameter logic [DATA_W-CTRL_W-1:0] KEY_B = 8'hA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [CTRL_W-1:0] ctrlOut,
  output logic              wdogEn,
  output logic              extraEn,
  output logic [DATA_W-1:0] rdData
);

  localparam int KEY_W = DATA_W - CTRL_W;

  ctrlStrobes_t strobes;

  keyed_ctrl_fsm #(.KEY_W(KEY_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) uFsm (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .keyByte(wrData[DATA_W-1:CTRL_W]),
    .strobes(strobes)
  );

  keyed_ctrl_dp #(.CTRL_W(CTRL_W), .LOW_RST(LOW_RST)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .lowByte(wrData[CTRL_W-1:0]),
    .ctrlOut(ctrlOut),
    .wdogEn (wdogEn),
    .extraEn(extraEn)
  );

  always_comb begin
    rdData              = '0;
    rdData[CTRL_W-1:0]  = ctrlOut;
    rdData[CTRL_W]      = wdogEn;
    rdData[CTRL_W+1]    = extraEn;
  end

  // R4: the watchdog enable only rises on a write carrying the second key
  a_r4_wdog_on_key: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdogEn) |-> ($past(wrEn) && $past(wrData[DATA_W-1:CTRL_W]) == KEY_B));

  // R5: the extra enable only rises on a write carrying the first key
  a_r5_extra_on_key: assert property (@(posedge clk) disable iff (!rstN)
    $rose(extraEn) |-> ($past(wrEn) && $past(wrData[DATA_W-1:CTRL_W]) == KEY_A));

endmodule

// File: tb/keyed_ctrl_reg_test.sv
module keyed_ctrl_reg_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [7:0]  ctrlOut;
  logic        wdogEn, extraEn;
  logic [15:0] rdData;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #2.5 clk = ~clk;

  keyed_ctrl_reg uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .ctrlOut(ctrlOut), .wdogEn(wdogEn), .extraEn(extraEn), .rdData(rdData)
  );

  // Behavioural reference: 0 idle, 1 saw E5, 2 saw A5
  int         mState;
  logic [7:0] mLow;
  bit         mWdog, mExtra;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mLow = 8'h70; mWdog = 0; mExtra = 0;
    end else if (wrEn) begin
      mLow = wrData[7:0];
      case (mState)
        0: mState = (wrData[15:8] == 8'hE5) ? 1 : (wrData[15:8] == 8'hA5) ? 2 : 0;
        1: if (wrData[15:8] == 8'hA5) begin mWdog = 1; mState = 0; end
           else if (wrData[15:8] != 8'hE5) mState = 0;
        default: if (wrData[15:8] == 8'hE5) begin mExtra = 1; mState = 0; end
           else if (wrData[15:8] != 8'hA5) mState = 0;
      endcase
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      chk("R2 ctrlOut", {8'h0, ctrlOut}, {8'h0, mLow});
      chk("R4 wdogEn", {15'h0, wdogEn}, {15'h0, mWdog});
      chk("R5 extraEn", {15'h0, extraEn}, {15'h0, mExtra});
      chk("R9 rdData", rdData, {6'h0, mExtra, mWdog, mLow});
    end
    if (cycles > 20000) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  task automatic wr(logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = 16'hFFFF;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    chk("R1 reset rdData", rdData, 16'h0070);
    chk("R1 reset ctrlOut", {8'h0, ctrlOut}, 16'h0070);
    idle(4);
    chk("R3 idle hold", rdData, 16'h0070);
    wr(16'h0055); chk("R2 low 55", {8'h0, ctrlOut}, 16'h0055);
    wr(16'h00AA); chk("R2 low AA", {8'h0, ctrlOut}, 16'h00AA);
    wr(16'h1201); chk("R2 single bit", {8'h0, ctrlOut}, 16'h0001);
    wr(16'h0080); chk("R2 clock enable bit", {8'h0, ctrlOut}, 16'h0080);
    // R6 interrupted watchdog sequence
    wr(16'hE500); wr(16'h3300); wr(16'hA511);
    chk("R6 abort wdog", {15'h0, wdogEn}, 16'h0);
    wr(16'h0000);
    // R7 repeated first byte
    wr(16'hE500); wr(16'hE502); idle(3); wr(16'hA504);
    chk("R7 repeat key wdog", {15'h0, wdogEn}, 16'h1);
    chk("R7 extra untouched", {15'h0, extraEn}, 16'h0);
    // R10 completion does not chain into the other sequence
    wr(16'hE500); wr(16'hA500); wr(16'hE500);
    chk("R10 no chain extra", {15'h0, extraEn}, 16'h0);
    wr(16'h0000);
    chk("R8 wdog sticky", {15'h0, wdogEn}, 16'h1);
    // R5 extra sequence with a gap
    wr(16'hA5C3); idle(2); wr(16'hE53C);
    chk("R5 extra set", {15'h0, extraEn}, 16'h1);
    wr(16'h0000);
    chk("R8 extra sticky", {15'h0, extraEn}, 16'h1);
    chk("R9 readback", rdData, 16'h0300);
    // reset again, extra first from clean state
    @(negedge clk); rstN = 1'b0; idle(2); rstN = 1'b1; idle(1);
    chk("R1 reset again", rdData, 16'h0070);
    wr(16'hA500); wr(16'h5A00); wr(16'hE500);
    chk("R6 abort extra", {15'h0, extraEn}, 16'h0);
    wr(16'h0000);
    wr(16'hA500); wr(16'hE5FF);
    chk("R5 extra only", rdData, 16'h02FF);
    wr(16'hE500); wr(16'hA501);
    chk("R4 wdog set", rdData, 16'h0301);
    idle(2);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule